// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns three asynchronous interrupt pins into pending-request flags for an interrupt controller. Each pin is brought into the clock domain through a two-flop synchronizer. It is then judged against a sense mode that software selects. Channels 0 and 1 offer four modes: low level, any edge, falling edge and rising edge. Channel 2 is edge-only, and a single bit picks its polarity.

An edge event sets a sticky flag. The flag stays set until the controller acknowledges the channel or software clears it. A level request is never stored. It appears only after the synchronized pin has stayed low for a qualification window, and it goes away as soon as the pin returns high. Changing a channel's mode discards any edge that is detected in the same cycle. Entering level mode drops a latched edge flag.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three flags read 0.
- R2: In rising mode (code 11 for channels 0 and 1, polarity bit 1 for channel 2), a 0-to-1 change on a pin that is first sampled at clock edge k sets that channel's flag. The flag is visible after edge k+2.
- R3: Falling mode (code 10, or polarity bit 0 on channel 2) flags only 1-to-0 changes. Any-edge mode (code 01) flags both directions. Both have the same latency as R2.
- R4: In any edge mode, a pin pulse that lasts one clock cycle is enough to set the flag.
- R5: In level mode (code 00, channels 0 and 1 only), the flag rises after edge k+6 when the pin is sampled low at edges k through k+4. Four low samples raise nothing.
- R6: A level request is not latched. Acknowledge has no effect on it. The request falls after edge j+2 when the pin is first sampled high at edge j.
- R7: A latched edge flag stays set until ack or sw_clr for that channel is sampled high. It then reads 0 after that edge.
- R8: An edge detected in the same cycle as an acknowledge or clear wins, so the flag stays set.
- R9: Channel 2 has no level mode. A pin held low after its falling edge has been acknowledged does not raise the flag again.
- R10: A mode write alone never sets a flag. An edge detected on the cycle where the mode differs from the previous cycle is discarded. Entering level mode clears a latched edge flag.
- R11: The three channels behave independently of each other under mixed traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin0 | input | 1 | Raw interrupt pin, channel 0 |
| pin1 | input | 1 | Raw interrupt pin, channel 1 |
| pin2 | input | 1 | Raw interrupt pin, channel 2 |
| mode0 | input | 2 | Channel 0 sense mode: 00 low, 01 any, 10 fall, 11 rise |
| mode1 | input | 2 | Channel 1 sense mode, same coding |
| pol2 | input | 1 | Channel 2 polarity: 0 fall, 1 rise |
| ack | input | 3 | Per-channel acknowledge from the controller |
| sw_clr | input | 3 | Per-channel software clear |
| flag | output | 3 | Per-channel pending request |

## Verification
The edge-polarity properties look four cycles back at the raw pin. They therefore assume that every pin sits high during reset and for at least four cycles after it. This matches the synchronizer's reset value, so a low pin at release cannot look like a falling edge. They also assume that pins, modes and clear strobes change only between clock edges. The stimulus holds all pins high through reset and a settling gap, and it drives every input on the falling clock edge.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int LEVEL_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin0,
  input  logic       pin1,
  input  logic       pin2,
  input  logic [1:0] mode0,
  input  logic [1:0] mode1,
  input  logic       pol2,
  input  logic [2:0] ack,
  input  logic [2:0] sw_clr,
  output logic [2:0] flag
);
  localparam int CW = $clog2(LEVEL_CYCLES + 1);
  localparam logic [CW-1:0] LVL_MAX = CW'(LEVEL_CYCLES);
  localparam logic [1:0] M_LOW  = 2'b00;
  localparam logic [1:0] M_ANY  = 2'b01;
  localparam logic [1:0] M_FALL = 2'b10;
  localparam logic [1:0] M_RISE = 2'b11;

  logic [2:0] raw;
  logic [1:0] md [3];

  assign raw   = {pin2, pin1, pin0};
  assign md[0] = mode0;
  assign md[1] = mode1;
  assign md[2] = {1'b1, pol2};

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic          meta, sync, prev, latched, level, changed, hit;
    logic [1:0]    mode_q;
    logic [CW-1:0] low_cnt;

    assign level   = (md[i] == M_LOW);
    assign changed = (md[i] != mode_q);

    always_comb begin
      case (md[i])
        M_ANY:   hit = sync ^ prev;
        M_FALL:  hit = prev & ~sync;
        M_RISE:  hit = sync & ~prev;
        default: hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b1;
        sync   <= 1'b1;
        prev   <= 1'b1;
        mode_q <= M_LOW;
      end else begin
        meta   <= raw[i];
        sync   <= meta;
        prev   <= sync;
        mode_q <= md[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   latched <= 1'b0;
      else if (level)               latched <= 1'b0;
      else if (hit && !changed)     latched <= 1'b1;
      else if (ack[i] || sw_clr[i]) latched <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (!level || sync)   low_cnt <= '0;
      else if (low_cnt != LVL_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign flag[i] = level ? (low_cnt == LVL_MAX) : latched;
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin0,
  input logic       pin1,
  input logic       pin2,
  input logic [1:0] mode0,
  input logic [1:0] mode1,
  input logic       pol2,
  input logic [2:0] ack,
  input logic [2:0] sw_clr,
  input logic [2:0] flag
);
  logic [2:0] pins;
  logic [1:0] md [3];
  assign pins  = {pin2, pin1, pin0};
  assign md[0] = mode0;
  assign md[1] = mode1;
  assign md[2] = {1'b1, pol2};

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flag == 3'b000);

  for (genvar i = 0; i < 3; i++) begin : g_p
    a_r2_rise_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag[i]) && $past(md[i]) == 2'b11) |-> ($past(pins[i], 3) && !$past(pins[i], 4)));

    a_r3_fall_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag[i]) && $past(md[i]) == 2'b10) |-> (!$past(pins[i], 3) && $past(pins[i], 4)));

    a_r7_clear_only_by_request: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flag[i]) && $past(md[i]) != 2'b00 && md[i] != 2'b00) |-> $past(ack[i] || sw_clr[i]));
  end

  for (genvar i = 0; i < 2; i++) begin : g_l
    a_r5_level_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      (md[i] == 2'b00 && flag[i]) |-> !$past(pins[i], 3));
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin0(pin0), .pin1(pin1), .pin2(pin2),
  .mode0(mode0), .mode1(mode1), .pol2(pol2), .ack(ack), .sw_clr(sw_clr), .flag(flag)
);

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
  localparam int LEVEL = 5;

  logic clk = 0, rst_n = 0, pin0 = 1, pin1 = 1, pin2 = 1, pol2 = 0;
  logic [1:0] mode0 = 2'b10, mode1 = 2'b11;
  logic [2:0] ack = 0, sw_clr = 0;
  logic [2:0] flag;
  int errors = 0, checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rst_n(rst_n), .pin0(pin0), .pin1(pin1), .pin2(pin2),
    .mode0(mode0), .mode1(mode1), .pol2(pol2), .ack(ack), .sw_clr(sw_clr), .flag(flag)
  );

  int hist [3][3];
  int lat [3], low [3], lastm [3];

  function automatic int mode_of(int i);
    if (i == 0) return int'(mode0);
    if (i == 1) return int'(mode1);
    return 2 + int'(pol2);
  endfunction

  function automatic int pin_of(int i);
    if (i == 0) return int'(pin0);
    if (i == 1) return int'(pin1);
    return int'(pin2);
  endfunction

  function automatic int exp_of(int i);
    if (mode_of(i) == 0) return (low[i] == LEVEL) ? 1 : 0;
    return lat[i];
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      int md, s, pv, det;
      if (!rst_n) begin
        hist[i][0] = 1; hist[i][1] = 1; hist[i][2] = 1;
        lat[i] = 0; low[i] = 0; lastm[i] = 0;
      end else begin
        md = mode_of(i);
        s  = hist[i][1];
        pv = hist[i][2];
        det = ((md == 1) && (s != pv)) || ((md == 2) && pv == 1 && s == 0) ||
              ((md == 3) && pv == 0 && s == 1);
        if (md == 0) lat[i] = 0;
        else if (det != 0 && md == lastm[i]) lat[i] = 1;
        else if (ack[i] || sw_clr[i]) lat[i] = 0;
        if (md == 0 && s == 0) low[i] = (low[i] < LEVEL) ? low[i] + 1 : LEVEL;
        else low[i] = 0;
        lastm[i] = md;
        hist[i][2] = hist[i][1];
        hist[i][1] = hist[i][0];
        hist[i][0] = pin_of(i);
      end
    end
  end

  task automatic chk(input int ch, input logic act, input int expv, input string req);
    checks++;
    if (int'(act) != expv) begin
      errors++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d at %0t", req, ch, act, expv, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      for (int i = 0; i < 3; i++) chk(i, flag[i], exp_of(i), cur_req);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(5);
    for (int i = 0; i < 3; i++) chk(i, flag[i], 0, "R1");

    cur_req = "R3"; pin0 = 0; tick(4); chk(0, flag[0], 1, "R3");
    cur_req = "R7"; ack = 3'b001; tick(1); ack = 0; tick(1); chk(0, flag[0], 0, "R7");
    cur_req = "R3"; pin0 = 1; tick(4); chk(0, flag[0], 0, "R3");

    cur_req = "R2"; pin1 = 0; tick(4); chk(1, flag[1], 0, "R2");
    pin1 = 1; tick(4); chk(1, flag[1], 1, "R2");
    cur_req = "R7"; sw_clr = 3'b010; tick(1); sw_clr = 0; chk(1, flag[1], 0, "R7");

    cur_req = "R4"; mode0 = 2'b01; tick(3);
    pin0 = 0; tick(1); pin0 = 1; tick(4); chk(0, flag[0], 1, "R4");
    ack = 3'b001; tick(1); ack = 0; tick(1); chk(0, flag[0], 0, "R4");
    cur_req = "R3"; pin0 = 0; tick(4); chk(0, flag[0], 1, "R3");
    ack = 3'b001; tick(1); ack = 0; tick(1); chk(0, flag[0], 0, "R3");
    pin0 = 1; tick(4); chk(0, flag[0], 1, "R3");
    ack = 3'b001; tick(1); ack = 0; tick(1);

    cur_req = "R9"; pin2 = 0; tick(4); chk(2, flag[2], 1, "R9");
    ack = 3'b100; tick(1); ack = 0; tick(8); chk(2, flag[2], 0, "R9");
    pol2 = 1; tick(3); chk(2, flag[2], 0, "R9");
    pin2 = 1; tick(4); chk(2, flag[2], 1, "R9");
    sw_clr = 3'b100; tick(1); sw_clr = 0; tick(1);

    cur_req = "R5"; mode0 = 2'b00; tick(3); chk(0, flag[0], 0, "R5");
    pin0 = 0; tick(4); pin0 = 1; tick(6); chk(0, flag[0], 0, "R5");
    pin0 = 0; tick(6); chk(0, flag[0], 0, "R5");
    tick(1); chk(0, flag[0], 1, "R5");
    cur_req = "R6"; ack = 3'b001; tick(2); ack = 0; chk(0, flag[0], 1, "R6");
    pin0 = 1; tick(2); chk(0, flag[0], 1, "R6");
    tick(1); chk(0, flag[0], 0, "R6");

    cur_req = "R8"; pin1 = 0; tick(4); pin1 = 1; tick(2);
    ack = 3'b010; tick(1); ack = 0; chk(1, flag[1], 1, "R8");
    ack = 3'b010; tick(1); ack = 0; chk(1, flag[1], 0, "R8");

    cur_req = "R10"; mode0 = 2'b01; tick(3); chk(0, flag[0], 0, "R10");
    pin0 = 0; tick(2); mode0 = 2'b10; tick(2); chk(0, flag[0], 0, "R10");
    pin0 = 1; tick(4); pin0 = 0; tick(4); chk(0, flag[0], 1, "R10");
    mode0 = 2'b00; tick(1); chk(0, flag[0], 0, "R10");
    mode0 = 2'b10; tick(1); chk(0, flag[0], 0, "R10");
    pin0 = 1; tick(4);

    cur_req = "R11";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(5) == 0) pin0 = ~pin0;
      if ($urandom_range(5) == 0) pin1 = ~pin1;
      if ($urandom_range(5) == 0) pin2 = ~pin2;
      for (int b = 0; b < 3; b++) begin
        ack[b]    = ($urandom_range(7) == 0);
        sw_clr[b] = ($urandom_range(15) == 0);
      end
      if (c % 200 == 199) begin
        mode0 = 2'($urandom_range(3));
        mode1 = 2'($urandom_range(3));
        pol2  = 1'($urandom_range(1));
      end
      tick(1);
    end
    ack = 0; sw_clr = 0; tick(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule